// File: doc/BRIEF.md
# Pause Flow-Control Status Register

This block keeps a record of the pause flow-control activity of one Ethernet MAC and reports it to software through a status word and a mask word. Three event sources feed it. The first is a strobe from the receive path that marks an accepted pause frame and carries the frame's 16-bit pause quanta. The other two are single-cycle indications from the transmitter that it has entered or left the paused state.

Each event sets a sticky bit in the status word, and the quanta of the most recent pause frame are held in the upper field of the same word. A registered interrupt output is raised while any event bit is set whose mask bit is clear. Software reads the status word to collect and clear the events. It writes the mask word to choose which events may interrupt.

The register port is a plain one-cycle select/read/write strobe. Read data is registered and appears on the cycle after the read strobe.

Top module: `pfc_stat_csr`

## Requirements
- R1: After reset the status word, the mask word, the read data and the interrupt are all zero.
- R2: A pause-frame strobe sets status bit 0 and loads its pause quanta into status bits 31:16 at the same clock edge; without a strobe, bits 31:16 keep their value, including across status reads.
- R3: An enter-paused pulse sets status bit 1 and a leave-paused pulse sets status bit 2; when both arrive in the same cycle, both bits are set.
- R4: Event bits 2:0 stay set until a status read (select 0, read strobe) and are cleared by that read; the read returns the word as it stood before the clear.
- R5: An event arriving in the same cycle as a clearing status read is kept: the bit is set after that edge, and the next read returns it.
- R6: Status bits 15:3 always read as zero; the mask word holds only bits 2:0, and its bits 31:3 read as zero whatever was written.
- R7: The interrupt is a register equal to the OR of (event bits AND NOT mask bits). It rises on the cycle after an unmasked event bit is latched and falls on the cycle after the last unmasked event bit clears.
- R8: A write with select 1 loads the mask at the strobe's edge; a masked event still latches in the status word but does not raise the interrupt.
- R9: A write with select 0 has no effect on the status word or the interrupt.
- R10: Reading the mask word (select 1) leaves the event bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pause_vld | input | 1 | One-cycle strobe: a pause frame was received |
| rx_pause_time | input | 16 | Pause quanta of that frame, valid with the strobe |
| tx_paused_enter | input | 1 | One-cycle pulse: transmitter entered the paused state |
| tx_paused_exit | input | 1 | One-cycle pulse: transmitter left the paused state |
| csr_sel | input | 1 | Register select: 0 status word, 1 mask word |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Registered read data, valid the cycle after a read strobe |
| pfc_irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the event inputs and the register strobes are synchronous and single-cycle. They also assume that the pause quanta are meaningful only while the receive strobe is high. The properties on the sticky bits and the interrupt are therefore written relative to the previous cycle's inputs and make no assumption about how far apart events fall. The directed bench changes its inputs only on the falling edge and holds every strobe for exactly one cycle. It deliberately places an event on the same cycle as a clearing read, and fires both transmitter pulses together, to reach the collision rules.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

   localparam int EVT_W = 3;

   localparam int EV_RX_PAUSE = 0;
   localparam int EV_ENTER    = 1;
   localparam int EV_EXIT     = 2;

   typedef enum logic {
      SEL_STATUS = 1'b0,
      SEL_MASK   = 1'b1
   } pfc_sel_e;

endpackage

// File: rtl/pfc_evt_latch.sv
module pfc_evt_latch #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_i,
   output logic [N-1:0] q_o
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q_o[i] <= 1'b0;
         else if (set_i[i])
            q_o[i] <= 1'b1;
         else if (clr_i)
            q_o[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/pfc_quanta_cap.sv
module pfc_quanta_cap #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_o <= '0;
      else if (load_i)
         q_o <= din_i;
   end

endmodule

// File: rtl/pfc_irq_gen.sv
module pfc_irq_gen #(
   parameter int N       = 3,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt_i,
   input  logic [N-1:0] mask_i,
   output logic         irq_o
);

   logic active;
   assign active = |(evt_i & ~mask_i);

   if (IRQ_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            irq_o <= 1'b0;
         else
            irq_o <= active;
      end
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign irq_o = active;
   end

endmodule

// File: rtl/pfc_stat_csr.sv
module pfc_stat_csr #(
   parameter int DATA_W   = 32,
   parameter int QUANTA_W = 16,
   parameter bit IRQ_REG  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_pause_vld,
   input  logic [QUANTA_W-1:0] rx_pause_time,
   input  logic                tx_paused_enter,
   input  logic                tx_paused_exit,
   input  logic                csr_sel,
   input  logic                csr_rd,
   input  logic                csr_wr,
   input  logic [DATA_W-1:0]   csr_wdata,
   output logic [DATA_W-1:0]   csr_rdata,
   output logic                pfc_irq
);
   import pfc_pkg::*;

   localparam int QLO = DATA_W - QUANTA_W;

   if (QUANTA_W < 1) begin : g_bad_quanta
      $error("pfc_stat_csr: QUANTA_W must be at least 1");
   end
   if (QLO < EVT_W) begin : g_bad_width
      $error("pfc_stat_csr: DATA_W too small for quanta field plus event bits");
   end

   logic [EVT_W-1:0]    evt_set;
   logic [EVT_W-1:0]    evt_q;
   logic [EVT_W-1:0]    mask_q;
   logic [QUANTA_W-1:0] quanta_q;
   logic [DATA_W-1:0]   sts_word;
   logic [DATA_W-1:0]   mask_word;
   logic                sts_clr;
   logic                mask_wr;
   logic                unused_wdata_hi;

   assign unused_wdata_hi = ^csr_wdata[DATA_W-1:EVT_W];

   assign evt_set[EV_RX_PAUSE] = rx_pause_vld;
   assign evt_set[EV_ENTER]    = tx_paused_enter;
   assign evt_set[EV_EXIT]     = tx_paused_exit;

   assign sts_clr = csr_rd  && (pfc_sel_e'(csr_sel) == SEL_STATUS);
   assign mask_wr = csr_wr  && (pfc_sel_e'(csr_sel) == SEL_MASK);

   pfc_evt_latch #(.N(EVT_W)) u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_set),
      .clr_i (sts_clr),
      .q_o   (evt_q)
   );

   pfc_quanta_cap #(.W(QUANTA_W)) u_quanta (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (rx_pause_vld),
      .din_i  (rx_pause_time),
      .q_o    (quanta_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (mask_wr)
         mask_q <= csr_wdata[EVT_W-1:0];
   end

   always_comb begin
      sts_word                 = '0;
      sts_word[EVT_W-1:0]      = evt_q;
      sts_word[DATA_W-1:QLO]   = quanta_q;
      mask_word                = '0;
      mask_word[EVT_W-1:0]     = mask_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         csr_rdata <= '0;
      else if (csr_rd)
         csr_rdata <= (pfc_sel_e'(csr_sel) == SEL_MASK) ? mask_word : sts_word;
   end

   pfc_irq_gen #(.N(EVT_W), .IRQ_REG(IRQ_REG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_q),
      .mask_i (mask_q),
      .irq_o  (pfc_irq)
   );

endmodule

// File: rtl/pfc_stat_sva.sv
module pfc_stat_sva #(
   parameter int DATA_W   = 32,
   parameter int QUANTA_W = 16,
   parameter bit IRQ_REG  = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rx_pause_vld,
   input logic [QUANTA_W-1:0] rx_pause_time,
   input logic                tx_paused_enter,
   input logic                tx_paused_exit,
   input logic                csr_sel,
   input logic                csr_rd,
   input logic                csr_wr,
   input logic [DATA_W-1:0]   sts,
   input logic [2:0]          msk,
   input logic                pfc_irq
);

   logic stat_rd;
   logic any_evt_in;
   assign stat_rd    = csr_rd && !csr_sel;
   assign any_evt_in = rx_pause_vld || tx_paused_enter || tx_paused_exit;

   AST_RX_SETS_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pause_vld |=> sts[0]); // R2
   AST_RX_LOADS_QUANTA: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pause_vld |=> sts[DATA_W-1 -: QUANTA_W] == $past(rx_pause_time)); // R2
   AST_QUANTA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_pause_vld |=> $stable(sts[DATA_W-1 -: QUANTA_W])); // R2
   AST_ENTER_SETS_BIT1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_paused_enter |=> sts[1]); // R3
   AST_EXIT_SETS_BIT2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_paused_exit |=> sts[2]); // R3
   AST_STICKY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd |=> (sts[2:0] & $past(sts[2:0])) == $past(sts[2:0])); // R4
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !any_evt_in) |=> sts[2:0] == 3'b000); // R4
   AST_MID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      sts[DATA_W-QUANTA_W-1:3] == '0); // R6
   AST_STATUS_WR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && !csr_sel && !any_evt_in && !stat_rd) |=> $stable(sts)); // R9

   if (IRQ_REG) begin : g_irq_chk
      AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
         (|(sts[2:0] & ~msk)) |=> pfc_irq); // R7
      AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
         !(|(sts[2:0] & ~msk)) |=> !pfc_irq); // R7
   end

endmodule

bind pfc_stat_csr pfc_stat_sva #(
   .DATA_W   (DATA_W),
   .QUANTA_W (QUANTA_W),
   .IRQ_REG  (IRQ_REG)
) u_sva (
   .clk             (clk),
   .rst_n           (rst_n),
   .rx_pause_vld    (rx_pause_vld),
   .rx_pause_time   (rx_pause_time),
   .tx_paused_enter (tx_paused_enter),
   .tx_paused_exit  (tx_paused_exit),
   .csr_sel         (csr_sel),
   .csr_rd          (csr_rd),
   .csr_wr          (csr_wr),
   .sts             (sts_word),
   .msk             (mask_q),
   .pfc_irq         (pfc_irq)
);

// File: tb/sim_pfc_stat_csr.sv
`timescale 1ns/1ps
module sim_pfc_stat_csr;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_pause_vld = 1'b0;
   logic [15:0] rx_pause_time = '0;
   logic        tx_paused_enter = 1'b0;
   logic        tx_paused_exit = 1'b0;
   logic        csr_sel = 1'b0;
   logic        csr_rd = 1'b0;
   logic        csr_wr = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        pfc_irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   pfc_stat_csr u0 (
      .clk             (clk),
      .rst_n           (rst_n),
      .rx_pause_vld    (rx_pause_vld),
      .rx_pause_time   (rx_pause_time),
      .tx_paused_enter (tx_paused_enter),
      .tx_paused_exit  (tx_paused_exit),
      .csr_sel         (csr_sel),
      .csr_rd          (csr_rd),
      .csr_wr          (csr_wr),
      .csr_wdata       (csr_wdata),
      .csr_rdata       (csr_rdata),
      .pfc_irq         (pfc_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic rd(input logic sel, output logic [31:0] v);
      csr_sel = sel; csr_rd = 1'b1;
      @(negedge clk);
      csr_rd = 1'b0;
      v = csr_rdata;
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      csr_sel = sel; csr_wr = 1'b1; csr_wdata = d;
      @(negedge clk);
      csr_wr = 1'b0; csr_wdata = '0;
   endtask

   task automatic pulse(input logic rx, input logic [15:0] t, input logic en, input logic ex);
      rx_pause_vld = rx; rx_pause_time = t; tx_paused_enter = en; tx_paused_exit = ex;
      @(negedge clk);
      rx_pause_vld = 1'b0; rx_pause_time = '0; tx_paused_enter = 1'b0; tx_paused_exit = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk("R1 irq", {31'd0, pfc_irq}, 32'd0);
      chk("R1 rdata", csr_rdata, 32'd0);
      rd(1'b0, v); chk("R1 status", v, 32'd0);
      rd(1'b1, v); chk("R1 mask", v, 32'd0);
   endtask

   task automatic t_rx_frame;
      logic [31:0] v;
      pulse(1'b1, 16'h1234, 1'b0, 1'b0);
      chk("R7 irq not yet", {31'd0, pfc_irq}, 32'd0);
      tick(1);
      chk("R7 irq rise", {31'd0, pfc_irq}, 32'd1);
      rd(1'b0, v);
      chk("R2 status", v, 32'h1234_0001);
      chk("R7 irq still high at clear edge", {31'd0, pfc_irq}, 32'd1);
      tick(1);
      chk("R7 irq fall", {31'd0, pfc_irq}, 32'd0);
      rd(1'b0, v);
      chk("R4 cleared, quanta kept R2", v, 32'h1234_0000);
   endtask

   task automatic t_both_tx;
      logic [31:0] v;
      pulse(1'b0, 16'h0, 1'b1, 1'b1);
      rd(1'b0, v);
      chk("R3 enter+exit same cycle", v, 32'h1234_0006);
      tick(1);
   endtask

   task automatic t_sticky;
      logic [31:0] v;
      pulse(1'b0, 16'h0, 1'b1, 1'b0);
      tick(5);
      rd(1'b1, v);
      chk("R10 mask read value", v, 32'h0);
      rd(1'b0, v);
      chk("R4 R10 sticky enter bit", v, 32'h1234_0002);
      tick(1);
   endtask

   task automatic t_collide;
      logic [31:0] v;
      pulse(1'b0, 16'h0, 1'b0, 1'b1);
      tx_paused_enter = 1'b1;
      rd(1'b0, v);
      tx_paused_enter = 1'b0;
      chk("R5 read returns pre-edge word", v, 32'h1234_0004);
      rd(1'b0, v);
      chk("R5 colliding event kept", v, 32'h1234_0002);
      tick(1);
   endtask

   task automatic t_mask;
      logic [31:0] v;
      wr(1'b1, 32'hFFFF_FFFF);
      rd(1'b1, v);
      chk("R6 mask readback", v, 32'h0000_0007);
      wr(1'b1, 32'h0000_0001);
      pulse(1'b1, 16'hABCD, 1'b0, 1'b0);
      tick(3);
      chk("R8 masked event no irq", {31'd0, pfc_irq}, 32'd0);
      pulse(1'b0, 16'h0, 1'b0, 1'b1);
      tick(1);
      chk("R8 unmasked event irq", {31'd0, pfc_irq}, 32'd1);
      rd(1'b0, v);
      chk("R8 masked event latched", v, 32'hABCD_0005);
      tick(1);
      chk("R7 irq fall after read", {31'd0, pfc_irq}, 32'd0);
      wr(1'b1, 32'h0);
   endtask

   task automatic t_wr_status;
      logic [31:0] v;
      wr(1'b0, 32'hFFFF_FFFF);
      tick(2);
      chk("R9 irq after status write", {31'd0, pfc_irq}, 32'd0);
      rd(1'b0, v);
      chk("R9 status unchanged", v, 32'hABCD_0000);
   endtask

   task automatic t_mid_bits;
      logic [31:0] v;
      pulse(1'b1, 16'hFFFF, 1'b1, 1'b1);
      rd(1'b0, v);
      chk("R6 bits 15:3 zero", v, 32'hFFFF_0007);
      tick(1);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset;
      t_rx_frame;
      t_both_tx;
      t_sticky;
      t_collide;
      t_mask;
      t_wr_status;
      t_mid_bits;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule